// File: doc/BRIEF.md
# Debug Message Output Serializer

This block takes finished trace messages from on-chip sources and sends them out over a narrow debug output port. A message has three parts: a 6-bit transfer code, a 4-bit source processor identifier, and a payload. The transfer code sets how many payload bits go out, so short messages take only a few slices of port time.

Accepted messages wait in a four-entry queue. A slicer takes one message at a time, cuts it into slices as wide as the port, and drives a 2-bit frame status next to each slice. The status marks the first slice, the middle slices and the last slice of a message. At run time the port runs either 8 bits wide or 2 bits wide.

A control enable gates the message path. The enable may be held high while reset is still asserted, so that traffic from the first cycle after reset can be captured. An idle gate holds the slicer registers still whenever there is nothing to send.

Top module: `dbg_msg_serializer`

## Requirements
- R1: Message bits go out least significant bit first, in this order: the 6 transfer code bits, then the 4 source identifier bits, then the payload bits.
- R2: The payload length depends on the transfer code. When transfer code bit 3 is 1, the payload is 64 bits. When bit 3 is 0, the payload is 8 times the value of code bits [2:0], so 0 to 56 bits. A message is 10 bits longer than its payload.
- R3: When `port_wide` is 1, slices are 8 bits on `tr_data[7:0]`. When it is 0, slices are 2 bits on `tr_data[1:0]` and `tr_data[7:2]` stays 0. The width is captured when a message is loaded and holds until that message ends.
- R4: `tr_frame` is 2'b01 on the first slice of a message, 2'b10 on a middle slice, 2'b11 on the last slice and 2'b00 when no slice is sent. A message takes ceil(length/width) slices.
- R5: Payload bits at or above the length set by the transfer code are not sent. The unused upper bits of the final slice are 0.
- R6: The queue holds 4 messages. `in_ready` is 1 exactly when `msg_en` is 1 and the queue is not full. A message is taken when `in_valid` and `in_ready` are both 1 at a clock edge.
- R7: If `in_valid` is 1 while `msg_en` is 1 and the queue is full, that message is dropped, and `ovf` is 1 for exactly the next cycle.
- R8: While `msg_en` is 0, `in_valid` is ignored and raises no overflow, and no new message starts. A message already being sent runs to its end. Queued messages are kept and go out once `msg_en` returns to 1.
- R9: With `msg_en` held at 1 through reset, `in_ready` is 1 during reset. A message offered in the first cycle after reset is accepted and sent.
- R10: When another message is queued, its first slice comes in the cycle right after the previous message's last slice, with no idle cycle between them.
- R11: Whenever `tr_frame` is 2'b00, `tr_data` is 0.
- R12: After reset, `tr_frame` is 2'b00, `tr_data` is 0 and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_en | input | 1 | Messaging enable from the debug control register |
| port_wide | input | 1 | 1 selects the 8-bit port, 0 selects the 2-bit port |
| in_valid | input | 1 | A source offers a message |
| in_ready | output | 1 | The queue can take a message |
| in_tcode | input | 6 | Transfer code of the offered message |
| in_src | input | 4 | Source processor identifier |
| in_payload | input | 64 | Payload bits, least significant bit first |
| tr_data | output | 8 | Output slice |
| tr_frame | output | 2 | Frame status of the current slice |
| ovf | output | 1 | One-cycle pulse when a message is dropped |

## Verification
Two events can fall in the same clock edge. One is the slicer sending the last slice of one message and loading the next message from the queue. The other is the queue being full while a source offers a message and no message leaves the queue. The bench provokes both with a burst of six long messages on the narrow port. The first message occupies the slicer for 37 cycles, so the queue fills and the sixth offer arrives at a full queue. The bench checks that only the sixth offer is refused and that `ovf` pulses for one cycle. It then checks from the recorded cycle numbers that each queued message starts in the cycle right after the previous message ends.

// File: rtl/dmo_pkg.sv
package dmo_pkg;

    localparam int TCODE_W = 6;
    localparam int SRC_W   = 4;
    localparam int PAY_W   = 64;
    localparam int HDR_W   = TCODE_W + SRC_W;
    localparam int MSG_W   = HDR_W + PAY_W;
    localparam int LEN_W   = $clog2(MSG_W + 1);

    typedef struct packed {
        logic [TCODE_W-1:0] tcode;
        logic [SRC_W-1:0]   src;
        logic [PAY_W-1:0]   payload;
    } dmo_msg_t;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'b00,
        FR_FIRST = 2'b01,
        FR_MID   = 2'b10,
        FR_LAST  = 2'b11
    } frame_e;

    // payload length in bits selected by the transfer code
    function automatic logic [LEN_W-1:0] payload_bits(input logic [TCODE_W-1:0] tc);
        logic [LEN_W-1:0] n;
        if (tc[3]) n = LEN_W'(PAY_W);
        else       n = LEN_W'({tc[2:0], 3'b000});
        return n;
    endfunction

    function automatic logic [LEN_W-1:0] total_bits(input logic [TCODE_W-1:0] tc);
        return LEN_W'(HDR_W) + payload_bits(tc);
    endfunction

    // lay out a message LSB first: code, source, trimmed payload
    function automatic logic [MSG_W-1:0] pack_msg(input dmo_msg_t m);
        logic [PAY_W-1:0] p;
        logic [LEN_W-1:0] plen;
        p    = m.payload;
        plen = payload_bits(m.tcode);
        for (int i = 0; i < PAY_W; i++) begin
            if (i >= int'(plen)) p[i] = 1'b0;
        end
        return {p, m.src, m.tcode};
    endfunction

endpackage

// File: rtl/dmo_fifo.sv
module dmo_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/dmo_idle_gate.sv
module dmo_idle_gate (
    input  logic msg_en,
    input  logic q_empty,
    input  logic busy,
    input  logic last,
    output logic load_en,
    output logic run_en
);
    // a new message may start only when enabled and the slicer is free or finishing
    assign load_en = msg_en && !q_empty && (!busy || last);
    // slicer registers advance only when there is work
    assign run_en  = busy || load_en;
endmodule

// File: rtl/dmo_slicer.sv
module dmo_slicer
    import dmo_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int NARROW_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              load,
    input  dmo_msg_t          msg,
    input  logic              wide,
    output logic              busy,
    output logic              last,
    output logic [PORT_W-1:0] dout,
    output frame_e            frame
);
    logic [MSG_W-1:0] sreg;
    logic [LEN_W-1:0] left;
    logic             busy_q, first_q, wide_q;
    logic [LEN_W-1:0] cur_w;

    assign cur_w = wide_q ? LEN_W'(PORT_W) : LEN_W'(NARROW_W);
    assign busy  = busy_q;
    assign last  = busy_q && (left <= cur_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            left    <= '0;
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            wide_q  <= 1'b0;
        end else if (run_en) begin
            if (load) begin
                sreg    <= pack_msg(msg);
                left    <= total_bits(msg.tcode);
                busy_q  <= 1'b1;
                first_q <= 1'b1;
                wide_q  <= wide;
            end else if (busy_q) begin
                sreg    <= wide_q ? (sreg >> PORT_W) : (sreg >> NARROW_W);
                left    <= left - cur_w;
                first_q <= 1'b0;
                if (last) busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PORT_W; i++) begin
            dout[i] = busy_q && (i < int'(cur_w)) && (i < int'(left)) && sreg[i];
        end
        if (!busy_q)      frame = FR_IDLE;
        else if (first_q) frame = FR_FIRST;
        else if (last)    frame = FR_LAST;
        else              frame = FR_MID;
    end
endmodule

// File: rtl/dbg_msg_serializer.sv
module dbg_msg_serializer
    import dmo_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int PORT_W   = 8,
    parameter int NARROW_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_en,
    input  logic               port_wide,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TCODE_W-1:0] in_tcode,
    input  logic [SRC_W-1:0]   in_src,
    input  logic [PAY_W-1:0]   in_payload,
    output logic [PORT_W-1:0]  tr_data,
    output logic [1:0]         tr_frame,
    output logic               ovf
);
    localparam int QW = $bits(dmo_msg_t);

    dmo_msg_t in_msg, q_msg;
    logic     q_empty, q_full, push, load_en, run_en, busy, last;
    frame_e   frame;
    logic     ovf_q;

    assign in_msg   = '{tcode: in_tcode, src: in_src, payload: in_payload};
    assign in_ready = msg_en && !q_full;
    assign push     = in_valid && in_ready;

    dmo_fifo #(.W(QW), .DEPTH(DEPTH)) queue_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (in_msg),
        .pop   (load_en),
        .dout  (q_msg),
        .empty (q_empty),
        .full  (q_full)
    );

    dmo_idle_gate gate_i (
        .msg_en  (msg_en),
        .q_empty (q_empty),
        .busy    (busy),
        .last    (last),
        .load_en (load_en),
        .run_en  (run_en)
    );

    dmo_slicer #(.PORT_W(PORT_W), .NARROW_W(NARROW_W)) slicer_i (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .load   (load_en),
        .msg    (q_msg),
        .wide   (port_wide),
        .busy   (busy),
        .last   (last),
        .dout   (tr_data),
        .frame  (frame)
    );

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= msg_en && in_valid && q_full;
    end

    assign tr_frame = frame;
    assign ovf      = ovf_q;
endmodule

// File: rtl/dbg_msg_serializer_chk.sv
module dbg_msg_serializer_chk (
    input logic       clk,
    input logic       rst,
    input logic       msg_en,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] tr_data,
    input logic [1:0] tr_frame,
    input logic       ovf
);
    a_r4_first_then_body: assert property (@(posedge clk) disable iff (rst)
        tr_frame == 2'b01 |=> (tr_frame == 2'b10 || tr_frame == 2'b11));

    a_r4_mid_continues: assert property (@(posedge clk) disable iff (rst)
        tr_frame == 2'b10 |=> (tr_frame == 2'b10 || tr_frame == 2'b11));

    a_r10_after_last: assert property (@(posedge clk) disable iff (rst)
        tr_frame == 2'b11 |=> (tr_frame == 2'b00 || tr_frame == 2'b01));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        tr_frame == 2'b00 |-> tr_data == 8'h00);

    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(in_valid && msg_en && !in_ready));

    a_r6_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> msg_en);

    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        tr_frame == 2'b01 |-> $past(msg_en));
endmodule

bind dbg_msg_serializer dbg_msg_serializer_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .msg_en   (msg_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tr_data  (tr_data),
    .tr_frame (tr_frame),
    .ovf      (ovf)
);

// File: tb/dbg_msg_serializer_tb_top.sv
module dbg_msg_serializer_tb_top;
    logic        clk = 1'b0, rst = 1'b1, msg_en = 1'b1, port_wide = 1'b1, in_valid = 1'b0;
    logic        in_ready, ovf;
    logic [5:0]  in_tcode = '0;
    logic [3:0]  in_src = '0;
    logic [63:0] in_payload = '0;
    logic [7:0]  tr_data;
    logic [1:0]  tr_frame;

    always #4 clk = ~clk;

    dbg_msg_serializer dut_i (
        .clk(clk), .rst(rst), .msg_en(msg_en), .port_wide(port_wide),
        .in_valid(in_valid), .in_ready(in_ready), .in_tcode(in_tcode),
        .in_src(in_src), .in_payload(in_payload), .tr_data(tr_data),
        .tr_frame(tr_frame), .ovf(ovf)
    );

    typedef struct { logic [79:0] bits; int len; } exp_t;
    exp_t sbq[$];
    int   t_start[$], t_end[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   done = 0;

    always @(posedge clk) cyc++;

    function automatic int tb_plen(input logic [5:0] tc);
        return tc[3] ? 64 : 8 * int'(tc[2:0]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: call at posedge+1; returns acceptance seen at the edge
    task automatic push(input logic [5:0] tc, input logic [3:0] s, input logic [63:0] p, output bit acc);
        exp_t e;
        in_tcode = tc; in_src = s; in_payload = p; in_valid = 1'b1;
        @(negedge clk);
        acc = in_ready;
        if (acc) begin
            e.len  = 10 + tb_plen(tc);
            e.bits = '0;
            e.bits[5:0] = tc;
            e.bits[9:6] = s;
            for (int i = 0; i < 64; i++) if (i < tb_plen(tc)) e.bits[10 + i] = p[i];
            sbq.push_back(e);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int k = 0;
        while ((sbq.size() != 0 || tr_frame != 2'b00) && k < 3000) begin
            @(negedge clk); k++;
        end
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: rebuild messages from slices and compare with scoreboard
    logic [79:0] racc;
    int          rpos = 0, nsl = 0, st = 0;
    bit          inmsg = 0, rwide = 0;

    task automatic take_slice();
        int w;
        w = rwide ? 8 : 2;
        for (int b = 0; b < 8; b++) begin
            if (b < w) begin
                if (rpos + b < 80) racc[rpos + b] = tr_data[b];
            end else if (tr_data[b]) begin
                chk(0, "R3 upper lanes zero in narrow mode", 80'(tr_data), 80'(0));
            end
        end
        rpos += w;
        nsl++;
    endtask

    task automatic finish_msg();
        exp_t e;
        bit   mism = 0, padbad = 0;
        int   w;
        w = rwide ? 8 : 2;
        if (sbq.size() == 0) begin
            chk(0, "R1 message with no expected entry", racc, 80'(0));
        end else begin
            e = sbq.pop_front();
            for (int i = 0; i < 80; i++) begin
                if (i < e.len) begin
                    if (racc[i] !== e.bits[i]) mism = 1;
                end else if (i < rpos && racc[i] !== 1'b0) padbad = 1;
            end
            chk(!mism && !padbad && nsl == (e.len + w - 1) / w,
                "R1 R2 R4 R5 message content, padding and slice count", racc, e.bits);
        end
        t_start.push_back(st);
        t_end.push_back(cyc);
        inmsg = 0;
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            case (tr_frame)
                2'b00: begin
                    if (inmsg)         chk(0, "R4 idle inside message", 80'(tr_frame), 80'(2));
                    if (tr_data != 0)  chk(0, "R11 data while idle", 80'(tr_data), 80'(0));
                end
                2'b01: begin
                    if (inmsg) chk(0, "R4 first slice inside message", 80'(tr_frame), 80'(2));
                    inmsg = 1; rwide = port_wide; racc = '0; rpos = 0; nsl = 0; st = cyc;
                    take_slice();
                end
                default: begin
                    if (!inmsg) chk(0, "R4 body slice without first", 80'(tr_frame), 80'(1));
                    else begin
                        take_slice();
                        if (tr_frame == 2'b11) finish_msg();
                    end
                end
            endcase
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        bit acc;
        bit accs[6];
        int base, bad;
        // reset with messaging already enabled
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready while in reset", 80'(in_ready), 80'(1));
        chk(tr_frame == 2'b00 && tr_data == 0, "R12 idle port in reset", 80'({tr_frame, tr_data}), 80'(0));
        chk(ovf == 1'b0, "R12 no overflow in reset", 80'(ovf), 80'(0));
        @(posedge clk); #1;
        rst = 1'b0;
        push(6'h0B, 4'h5, 64'h1122_3344_5566_7788, acc);
        chk(acc, "R9 accepted on first cycle after reset", 80'(acc), 80'(1));
        drain();
        chk(t_start.size() == 1, "R9 first message sent", 80'(t_start.size()), 80'(1));

        // assorted codes on the wide port, then the narrow port
        for (int pass = 0; pass < 2; pass++) begin
            port_wide = (pass == 0);
            push(6'h00, 4'h1, 64'hFFFF_FFFF_FFFF_FFFF, acc); chk(acc, "R6 accepted with space", 80'(acc), 80'(1));
            push(6'h31, 4'hA, 64'hFFFF_FFFF_FFFF_FFA5, acc); chk(acc, "R6 accepted with space", 80'(acc), 80'(1));
            push(6'h07, 4'h3, 64'hDEAD_BEEF_0BAD_F00D, acc); chk(acc, "R6 accepted with space", 80'(acc), 80'(1));
            push(6'h2C, 4'hF, 64'h0123_4567_89AB_CDEF ^ 64'(pass), acc);
            push(6'h12, 4'h6, 64'hAAAA_AAAA_AAAA_5A3C, acc);
            drain();
        end

        // burst: queue fills while the slicer is busy on the narrow port
        port_wide = 1'b0;
        base = t_start.size();
        for (int k = 0; k < 6; k++) push(6'h08, 4'(k), {32'hC0DE_0000, 32'(k)}, accs[k]);
        for (int k = 0; k < 5; k++) chk(accs[k], "R6 accepted until full", 80'(accs[k]), 80'(1));
        chk(!accs[5], "R6 R7 offer refused when full", 80'(accs[5]), 80'(0));
        @(negedge clk);
        chk(ovf == 1'b1, "R7 overflow pulse after drop", 80'(ovf), 80'(1));
        chk(in_ready == 1'b0, "R6 ready low while full", 80'(in_ready), 80'(0));
        @(negedge clk);
        chk(ovf == 1'b0, "R7 overflow lasts one cycle", 80'(ovf), 80'(0));
        @(posedge clk); #1;
        drain();
        chk(t_start.size() == base + 5, "R7 only five burst messages sent", 80'(t_start.size() - base), 80'(5));
        for (int k = 0; k < 4; k++)
            chk(t_start[base + k + 1] == t_end[base + k] + 1, "R10 back-to-back start",
                80'(t_start[base + k + 1]), 80'(t_end[base + k] + 1));

        // disabled: offers ignored, port idle
        msg_en = 1'b0;
        base = t_start.size();
        push(6'h03, 4'h2, 64'h55, acc);
        chk(!acc, "R8 offer ignored while disabled", 80'(acc), 80'(1'b0));
        @(negedge clk);
        chk(ovf == 1'b0, "R8 no overflow while disabled", 80'(ovf), 80'(0));
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tr_frame != 2'b00 || tr_data != 0) bad++;
        end
        chk(bad == 0 && t_start.size() == base, "R8 R11 port idle while disabled", 80'(bad), 80'(0));

        // disable in the middle of a message: it finishes, the next one waits
        @(posedge clk); #1;
        msg_en = 1'b1;
        push(6'h08, 4'h9, 64'h8765_4321_0FED_CBA9, acc);
        push(6'h02, 4'h4, 64'h0000_0000_0000_9C3E, acc);
        while (tr_frame != 2'b01) @(negedge clk);
        @(posedge clk); #1;
        msg_en = 1'b0;
        while (t_start.size() < base + 1) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (tr_frame != 2'b00) bad++;
        end
        chk(bad == 0 && sbq.size() == 1, "R8 queued message held while disabled", 80'(sbq.size()), 80'(1));
        @(posedge clk); #1;
        msg_en = 1'b1;
        drain();
        chk(sbq.size() == 0 && t_start.size() == base + 2, "R8 held message sent after enable",
            80'(t_start.size() - base), 80'(2));

        // width captured at load: switch to wide after the first narrow slice
        port_wide = 1'b0;
        push(6'h05, 4'hC, 64'h0000_00F0_E1D2_C3B4, acc);
        while (tr_frame != 2'b01) @(negedge clk);
        @(posedge clk); #1;
        port_wide = 1'b1;
        drain();
        chk(sbq.size() == 0, "R3 narrow message kept its width", 80'(sbq.size()), 80'(0));

        summary();
    end
endmodule